// File: doc/BRIEF.md
# Cascadable Dual-Clock FIFO with Fill Flags

This block is an 18-bit first-in first-out buffer. Its write port and its read port each have their own clock, and each port is qualified by an active-low enable. The two clocks may run unrelated to each other, or they may be one shared clock. Each pointer crosses into the other domain as Gray code through a two-flop synchronizer. Full and almost full are computed in the write domain. Empty and almost empty are computed in the read domain. Every flag is a register loaded from the next-state pointer, so a flag that must assert does so in the cycle that follows the operation that caused it.

In stand-alone use the block also offers three controls. A half-full indication comes out on the write token pin. A retransmit control rewinds the read side to the first word written since reset. An output enable releases the data bus.

With `chain_en` high, several identical instances form a ring and act as one deeper FIFO. They share the write and read buses. A write token and a read token circulate around the ring. The instance strapped with `first_load_n` low holds both tokens after reset. An instance hands on a token after it writes, or reads, the last location of its storage.

Top module: `cascade_fifo`

## Requirements
- R1: While reset is asserted, and after it is released with no traffic, `empty_n` and `aempty_n` are 0. `full_n`, `afull_n` and the stand-alone half-full output `wtok_out_n` are 1. The read data register holds 0.
- R2: Words accepted with `wr_en_n` low at rising `wr_clk` edges are returned in the same order by reads with `rd_en_n` low. Each word appears on `dout` after the `rd_clk` edge that accepts the read.
- R3: A write while `full_n` is 0 is ignored and changes no stored word. `full_n` goes to 0 in the cycle after the write that makes the fill DEPTH.
- R4: A read while `empty_n` is 0 is ignored and does not advance the read side. `empty_n` goes to 0 in the cycle after the read that makes the fill 0.
- R5: Once both pointers have settled, `aempty_n` is 0 exactly when the fill is at most `ae_lvl`.
- R6: Once both pointers have settled, `afull_n` is 0 exactly when the fill is at least DEPTH minus `af_lvl`.
- R7: With `chain_en` 0, once both pointers have settled, `wtok_out_n` is 0 exactly when the fill exceeds DEPTH/2.
- R8: With `chain_en` 0, holding `rt_n` low for one read clock with no read returns the read side to the first word written since reset. This holds while fewer than DEPTH words have been written since reset. Later reads replay the words in their original order.
- R9: While `oe_n` is 1, `dout` is not driven. Lowering `oe_n` presents the registered read word.
- R10: With `chain_en` 1, an instance accepts writes only while it holds the write token, and reads only while it holds the read token. After it writes (or reads) its last location it pulses `wtok_out_n` (or `rtok_out_n`) low for one cycle. The next instance uses a word in the same cycle it sees that pulse, so the ring stores and returns words in order without a gap. The instance with `first_load_n` low starts with both tokens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| chain_en | input | 1 | 1 selects ring (depth expansion) operation; strap |
| first_load_n | input | 1 | Low on the instance that owns both tokens after reset |
| wr_en_n | input | 1 | Active-low write enable |
| din | input | 18 | Write data |
| rd_en_n | input | 1 | Active-low read enable |
| rt_n | input | 1 | Active-low retransmit, stand-alone only |
| oe_n | input | 1 | Active-low output enable for `dout` |
| ae_lvl | input | $clog2(DEPTH) | Almost-empty threshold |
| af_lvl | input | $clog2(DEPTH) | Almost-full offset from DEPTH |
| dout | output | 18 | Read data, high-impedance when not enabled |
| empty_n | output | 1 | Active-low empty, read domain |
| aempty_n | output | 1 | Active-low almost empty, read domain |
| afull_n | output | 1 | Active-low almost full, write domain |
| full_n | output | 1 | Active-low full, write domain |
| wtok_in_n | input | 1 | Write token from the previous instance in the ring |
| wtok_out_n | output | 1 | Write token pulse in a ring; active-low half full when stand-alone |
| rtok_in_n | input | 1 | Read token from the previous instance in the ring |
| rtok_out_n | output | 1 | Read token pulse in a ring; 1 when stand-alone |

## Verification
The bench fills the buffer to exactly DEPTH and then keeps writing a distinctive word. A design that let the pointer wrap would overwrite the oldest word, and the drain would show the wrong data. It reads an empty buffer before writing. A read pointer that slipped would return a stale location in place of the next word. It stops at fills that sit just either side of each threshold, so an off-by-one comparison shows up as a wrong flag. It drives a two-instance ring through both token hand-overs with the enables held low. A late token take would drop or duplicate a word at the boundary, and a pulse longer than one cycle would show on the token pins.

// File: rtl/cfifo_pkg.sv
package cfifo_pkg;
  localparam int DW = 18;
  typedef logic [DW-1:0] word_t;
endpackage

// File: rtl/cfifo_sync.sv
// Two-flop synchronizer; also used with d tied high as a reset release stage.
module cfifo_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/cfifo_wr.sv
// Write domain: pointer, full / almost full / half flags, write token.
module cfifo_wr #(
  parameter  int AW = 4,
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_n,
  input  logic          chain_en,
  input  logic          first_load_n,
  input  logic          tok_in_n,
  input  logic [PW-1:0] rgray_s,
  input  logic [AW-1:0] af_lvl,
  output logic [PW-1:0] wbin,
  output logic [PW-1:0] wgray,
  output logic [AW-1:0] waddr,
  output logic          wr_go,
  output logic          tok_held,
  output logic          full_n,
  output logic          afull_n,
  output logic          tok_out_n
);
  localparam logic [PW-1:0] DEPTH_V = {1'b1, {AW{1'b0}}};
  localparam logic [PW-1:0] HALF_V  = DEPTH_V >> 1;

  logic [PW-1:0] rbin, bin_nx, fill_nx;
  logic tok_q, tok_nx, pulse_q, pulse_nx;
  logic full_q, full_nx, af_q, af_nx, half_q, half_nx, last;

  always_comb begin
    for (int i = 0; i < PW; i++) rbin[i] = ^(rgray_s >> i);
  end

  always_comb begin
    tok_held = !chain_en || tok_q || !tok_in_n;
    wr_go    = !wr_en_n && !full_q && tok_held;
    bin_nx   = wbin + PW'(wr_go);
    fill_nx  = bin_nx - rbin;
    last     = wr_go && (wbin[AW-1:0] == {AW{1'b1}});
    tok_nx   = tok_q;
    pulse_nx = 1'b0;
    if (chain_en) begin
      if (!tok_in_n) tok_nx = 1'b1;
      if (last) begin
        tok_nx   = 1'b0;
        pulse_nx = 1'b1;
      end
    end
    full_nx = (fill_nx == DEPTH_V);
    af_nx   = (fill_nx >= DEPTH_V - PW'(af_lvl));
    half_nx = (fill_nx > HALF_V);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin    <= '0;
      wgray   <= '0;
      tok_q   <= !first_load_n;
      pulse_q <= 1'b0;
      full_q  <= 1'b0;
      af_q    <= 1'b0;
      half_q  <= 1'b0;
    end else begin
      if (wr_go) begin
        wbin  <= bin_nx;
        wgray <= bin_nx ^ (bin_nx >> 1);
      end
      tok_q   <= tok_nx;
      pulse_q <= pulse_nx;
      full_q  <= full_nx;
      af_q    <= af_nx;
      half_q  <= half_nx;
    end
  end

  assign waddr     = wbin[AW-1:0];
  assign full_n    = !full_q;
  assign afull_n   = !af_q;
  assign tok_out_n = chain_en ? !pulse_q : !half_q;
endmodule

// File: rtl/cfifo_rd.sv
// Read domain: pointer, empty / almost empty flags, retransmit, read token.
module cfifo_rd #(
  parameter  int AW = 4,
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en_n,
  input  logic          rt_n,
  input  logic          chain_en,
  input  logic          first_load_n,
  input  logic          tok_in_n,
  input  logic [PW-1:0] wgray_s,
  input  logic [AW-1:0] ae_lvl,
  output logic [PW-1:0] rbin,
  output logic [PW-1:0] rgray,
  output logic [AW-1:0] raddr,
  output logic          rd_go,
  output logic          tok_held,
  output logic          drive,
  output logic          empty_n,
  output logic          aempty_n,
  output logic          tok_out_n
);
  logic [PW-1:0] wbin, bin_nx, fill_nx;
  logic tok_q, tok_nx, pulse_q, pulse_nx;
  logic empty_q, empty_nx, ae_q, ae_nx, rt, last;

  always_comb begin
    for (int i = 0; i < PW; i++) wbin[i] = ^(wgray_s >> i);
  end

  always_comb begin
    rt       = !rt_n && !chain_en;
    tok_held = !chain_en || tok_q || !tok_in_n;
    rd_go    = !rd_en_n && !empty_q && tok_held && !rt;
    bin_nx   = rt ? '0 : rbin + PW'(rd_go);
    fill_nx  = wbin - bin_nx;
    last     = rd_go && (rbin[AW-1:0] == {AW{1'b1}});
    tok_nx   = tok_q;
    pulse_nx = 1'b0;
    if (chain_en) begin
      if (!tok_in_n) tok_nx = 1'b1;
      if (last) begin
        tok_nx   = 1'b0;
        pulse_nx = 1'b1;
      end
    end
    empty_nx = (fill_nx == '0);
    ae_nx    = (fill_nx <= PW'(ae_lvl));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin    <= '0;
      rgray   <= '0;
      tok_q   <= !first_load_n;
      pulse_q <= 1'b0;
      empty_q <= 1'b1;
      ae_q    <= 1'b1;
    end else begin
      if (rd_go || rt) begin
        rbin  <= bin_nx;
        rgray <= bin_nx ^ (bin_nx >> 1);
      end
      tok_q   <= tok_nx;
      pulse_q <= pulse_nx;
      empty_q <= empty_nx;
      ae_q    <= ae_nx;
    end
  end

  assign raddr     = rbin[AW-1:0];
  assign drive     = !chain_en || tok_q || pulse_q;
  assign empty_n   = !empty_q;
  assign aempty_n  = !ae_q;
  assign tok_out_n = chain_en ? !pulse_q : 1'b1;
endmodule

// File: rtl/cascade_fifo.sv
module cascade_fifo
  import cfifo_pkg::*;
#(
  parameter  int DEPTH = 2048,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = AW + 1
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          rst_n,
  input  logic          chain_en,
  input  logic          first_load_n,
  input  logic          wr_en_n,
  input  logic [DW-1:0] din,
  input  logic          rd_en_n,
  input  logic          rt_n,
  input  logic          oe_n,
  input  logic [AW-1:0] ae_lvl,
  input  logic [AW-1:0] af_lvl,
  output wire  [DW-1:0] dout,
  output logic          empty_n,
  output logic          aempty_n,
  output logic          afull_n,
  output logic          full_n,
  input  logic          wtok_in_n,
  output logic          wtok_out_n,
  input  logic          rtok_in_n,
  output logic          rtok_out_n
);
  logic          wr_rst_n, rd_rst_n;
  logic [PW-1:0] wbin, wgray, rbin, rgray, wgray_s, rgray_s;
  logic [AW-1:0] waddr, raddr;
  logic          wr_go, rd_go, wtok_held, rtok_held, rd_drive;
  word_t         mem [DEPTH];
  word_t         rdata_q;

  cfifo_sync #(.W(1)) u_wrst (.clk(wr_clk), .arst_n(rst_n), .d(1'b1), .q(wr_rst_n));
  cfifo_sync #(.W(1)) u_rrst (.clk(rd_clk), .arst_n(rst_n), .d(1'b1), .q(rd_rst_n));
  cfifo_sync #(.W(PW)) u_r2w (.clk(wr_clk), .arst_n(wr_rst_n), .d(rgray), .q(rgray_s));
  cfifo_sync #(.W(PW)) u_w2r (.clk(rd_clk), .arst_n(rd_rst_n), .d(wgray), .q(wgray_s));

  cfifo_wr #(.AW(AW)) u_wr (
    .clk(wr_clk), .rst_n(wr_rst_n), .wr_en_n(wr_en_n), .chain_en(chain_en),
    .first_load_n(first_load_n), .tok_in_n(wtok_in_n), .rgray_s(rgray_s),
    .af_lvl(af_lvl), .wbin(wbin), .wgray(wgray), .waddr(waddr), .wr_go(wr_go),
    .tok_held(wtok_held), .full_n(full_n), .afull_n(afull_n), .tok_out_n(wtok_out_n)
  );

  cfifo_rd #(.AW(AW)) u_rd (
    .clk(rd_clk), .rst_n(rd_rst_n), .rd_en_n(rd_en_n), .rt_n(rt_n),
    .chain_en(chain_en), .first_load_n(first_load_n), .tok_in_n(rtok_in_n),
    .wgray_s(wgray_s), .ae_lvl(ae_lvl), .rbin(rbin), .rgray(rgray), .raddr(raddr),
    .rd_go(rd_go), .tok_held(rtok_held), .drive(rd_drive), .empty_n(empty_n),
    .aempty_n(aempty_n), .tok_out_n(rtok_out_n)
  );

  // Storage: written in the write domain, read into a register in the read domain.
  always_ff @(posedge wr_clk) begin
    if (wr_go) mem[waddr] <= din;
  end

  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n) rdata_q <= '0;
    else if (rd_go) rdata_q <= mem[raddr];
  end

  assign dout = (!oe_n && rd_drive) ? rdata_q : 'z;
endmodule

// File: rtl/cfifo_chk.sv
module cfifo_chk #(
  parameter  int AW = 4,
  localparam int PW = AW + 1
) (
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          wr_rst_n,
  input logic          rd_rst_n,
  input logic          chain_en,
  input logic          wr_en_n,
  input logic          rd_en_n,
  input logic          rt_n,
  input logic          full_n,
  input logic          afull_n,
  input logic          empty_n,
  input logic          aempty_n,
  input logic          wtok_out_n,
  input logic          rtok_out_n,
  input logic          wtok_held,
  input logic          rtok_held,
  input logic [PW-1:0] wbin,
  input logic [PW-1:0] rbin
);
  // R3
  full_block_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (!full_n && !wr_en_n) |=> $stable(wbin));

  // R4
  empty_block_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (!empty_n && !rd_en_n && rt_n) |=> $stable(rbin));

  // R6
  full_has_af_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    !full_n |-> !afull_n);

  // R5
  empty_has_ae_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    !empty_n |-> !aempty_n);

  // R10
  wtok_pulse_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (chain_en && !wtok_out_n) |=> wtok_out_n);

  // R10
  rtok_pulse_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (chain_en && !rtok_out_n) |=> rtok_out_n);

  // R10
  no_token_write_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (chain_en && !wtok_held) |=> $stable(wbin));

  // R10
  no_token_read_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (chain_en && !rtok_held) |=> $stable(rbin));
endmodule

bind cascade_fifo cfifo_chk #(.AW(AW)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .wr_rst_n(wr_rst_n), .rd_rst_n(rd_rst_n),
  .chain_en(chain_en), .wr_en_n(wr_en_n), .rd_en_n(rd_en_n), .rt_n(rt_n),
  .full_n(full_n), .afull_n(afull_n), .empty_n(empty_n), .aempty_n(aempty_n),
  .wtok_out_n(wtok_out_n), .rtok_out_n(rtok_out_n), .wtok_held(wtok_held),
  .rtok_held(rtok_held), .wbin(wbin), .rbin(rbin)
);

// File: tb/test_cascade_fifo.sv
module test_cascade_fifo;
  import cfifo_pkg::*;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n;
  logic s_wen_n, s_ren_n, s_rt_n, s_oe_n;
  word_t s_din;
  wire [17:0] s_dout;
  logic s_empty_n, s_aempty_n, s_afull_n, s_full_n, s_half_n, s_rtok_n;

  logic c_wen_n, c_ren_n;
  word_t c_din;
  wire [17:0] c_dout0, c_dout1;
  logic w0, w1, r0, r1;
  logic a_e, a_ae, a_af, a_f, b_e, b_ae, b_af, b_f;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  string tag = "R2";
  word_t q[$];
  word_t hist[$];
  int wcnt = 0;

  cascade_fifo #(.DEPTH(DEPTH)) i_cascade_fifo (
    .wr_clk(clk), .rd_clk(clk), .rst_n(rst_n), .chain_en(1'b0), .first_load_n(1'b0),
    .wr_en_n(s_wen_n), .din(s_din), .rd_en_n(s_ren_n), .rt_n(s_rt_n), .oe_n(s_oe_n),
    .ae_lvl(4'd3), .af_lvl(4'd4), .dout(s_dout), .empty_n(s_empty_n),
    .aempty_n(s_aempty_n), .afull_n(s_afull_n), .full_n(s_full_n),
    .wtok_in_n(1'b1), .wtok_out_n(s_half_n), .rtok_in_n(1'b1), .rtok_out_n(s_rtok_n)
  );

  cascade_fifo #(.DEPTH(DEPTH)) i_ring0 (
    .wr_clk(clk), .rd_clk(clk), .rst_n(rst_n), .chain_en(1'b1), .first_load_n(1'b0),
    .wr_en_n(c_wen_n), .din(c_din), .rd_en_n(c_ren_n), .rt_n(1'b1), .oe_n(1'b0),
    .ae_lvl(4'd3), .af_lvl(4'd4), .dout(c_dout0), .empty_n(a_e), .aempty_n(a_ae),
    .afull_n(a_af), .full_n(a_f), .wtok_in_n(w1), .wtok_out_n(w0),
    .rtok_in_n(r1), .rtok_out_n(r0)
  );

  cascade_fifo #(.DEPTH(DEPTH)) i_ring1 (
    .wr_clk(clk), .rd_clk(clk), .rst_n(rst_n), .chain_en(1'b1), .first_load_n(1'b1),
    .wr_en_n(c_wen_n), .din(c_din), .rd_en_n(c_ren_n), .rt_n(1'b1), .oe_n(1'b0),
    .ae_lvl(4'd3), .af_lvl(4'd4), .dout(c_dout1), .empty_n(b_e), .aempty_n(b_ae),
    .afull_n(b_af), .full_n(b_f), .wtok_in_n(w0), .wtok_out_n(w1),
    .rtok_in_n(r0), .rtok_out_n(r1)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic word_t next_word();
    wcnt++;
    return 18'(wcnt * 37 + 5) ^ 18'h15A5A;
  endfunction

  // One clock of stimulus on the stand-alone instance, checked against the model.
  task automatic step(input bit w, input word_t d, input bit r, input bit rt);
    bit wacc, racc;
    word_t e;
    s_wen_n = !w; s_din = d; s_ren_n = !r; s_rt_n = !rt;
    wacc = w && s_full_n;
    racc = r && s_empty_n && !rt;
    @(posedge clk);
    @(negedge clk);
    if (rt) q = hist;
    if (wacc) begin
      q.push_back(d);
      hist.push_back(d);
    end
    if (racc) begin
      if (q.size() == 0) chk(1'b0, "R4 read accepted while empty", 1, 0);
      else begin
        e = q.pop_front();
        if (s_oe_n) begin
          chk(s_dout !== e, "R9 bus driven with oe_n high", int'(s_dout), int'(e));
          s_oe_n = 1'b0;
          #1;
          chk(s_dout === e, "R9 word after oe_n low", int'(s_dout), int'(e));
        end else begin
          chk(s_dout === e, tag, int'(s_dout), int'(e));
        end
      end
    end
    chk(q.size() <= DEPTH, "R3 overflow", q.size(), DEPTH);
    if (q.size() == DEPTH) chk(!s_full_n, "R3 full_n after fill", int'(s_full_n), 0);
    if (q.size() == 0) chk(!s_empty_n, "R4 empty_n after drain", int'(s_empty_n), 0);
    s_wen_n = 1'b1; s_ren_n = 1'b1; s_rt_n = 1'b1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, '0, 1'b0, 1'b0);
  endtask

  task automatic put(input int n);
    for (int i = 0; i < n; i++) step(1'b1, next_word(), 1'b0, 1'b0);
  endtask

  task automatic settled(input int f);
    chk(s_empty_n == (f != 0), "R4 settled empty_n", int'(s_empty_n), int'(f != 0));
    chk(s_aempty_n == (f > 3), "R5 settled aempty_n", int'(s_aempty_n), int'(f > 3));
    chk(s_full_n == (f != DEPTH), "R3 settled full_n", int'(s_full_n), int'(f != DEPTH));
    chk(s_afull_n == (f < 12), "R6 settled afull_n", int'(s_afull_n), int'(f < 12));
    chk(s_half_n == !(f > 8), "R7 settled half", int'(s_half_n), int'(!(f > 8)));
  endtask

  task automatic check_reset_state();
    chk(s_empty_n == 1'b0, "R1 empty_n", int'(s_empty_n), 0);
    chk(s_aempty_n == 1'b0, "R1 aempty_n", int'(s_aempty_n), 0);
    chk(s_full_n == 1'b1, "R1 full_n", int'(s_full_n), 1);
    chk(s_afull_n == 1'b1, "R1 afull_n", int'(s_afull_n), 1);
    chk(s_half_n == 1'b1, "R1 half", int'(s_half_n), 1);
    chk(s_dout === 18'h0, "R1 dout", int'(s_dout), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R2 watchdog expired act=%0d exp=%0d", total, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    s_wen_n = 1'b1; s_ren_n = 1'b1; s_rt_n = 1'b1; s_oe_n = 1'b0; s_din = '0;
    c_wen_n = 1'b1; c_ren_n = 1'b1; c_din = '0;
    repeat (3) @(negedge clk);
    check_reset_state();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_reset_state();

    // R4: reads on an empty buffer are ignored
    step(1'b0, '0, 1'b1, 1'b0);
    step(1'b0, '0, 1'b1, 1'b0);
    idle(6); settled(0);

    // R5/R6/R7: fills on both sides of each threshold
    put(3); idle(6); settled(3);
    put(1); idle(6); settled(4);
    put(4); idle(6); settled(8);
    put(1); idle(6); settled(9);
    put(2); idle(6); settled(11);
    put(1); idle(6); settled(12);
    put(4); idle(6); settled(16);

    // R3: writes while full are ignored
    step(1'b1, 18'h3FFFF, 1'b0, 1'b0);
    step(1'b1, 18'h3FFFF, 1'b0, 1'b0);
    idle(6); settled(16);

    // R2: mixed concurrent traffic, then drain
    for (int i = 0; i < 60; i++)
      step((i % 3) != 0, next_word(), (i % 2 == 0) || (i % 5 == 1), 1'b0);
    for (int i = 0; i < 48; i++) step(1'b0, '0, 1'b1, 1'b0);
    chk(q.size() == 0, "R2 drained", q.size(), 0);
    idle(6); settled(0);

    // R4: a read on empty followed by a write must return the new word
    step(1'b0, '0, 1'b1, 1'b0);
    put(1); idle(6);
    step(1'b0, '0, 1'b1, 1'b0);
    idle(6); settled(0);

    // R8: retransmit after a fresh reset
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    q.delete(); hist.delete();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    put(5); idle(6);
    for (int i = 0; i < 3; i++) step(1'b0, '0, 1'b1, 1'b0);
    idle(2);
    tag = "R8 replay after retransmit";
    step(1'b0, '0, 1'b0, 1'b1);
    idle(6);
    chk(s_empty_n == 1'b1, "R8 not empty after retransmit", int'(s_empty_n), 1);
    for (int i = 0; i < 5; i++) step(1'b0, '0, 1'b1, 1'b0);
    chk(q.size() == 0, "R8 replay count", q.size(), 0);
    tag = "R2";
    idle(6); settled(0);

    // R9: output enable
    step(1'b1, 18'h2AAAA, 1'b0, 1'b0);
    idle(6);
    s_oe_n = 1'b1;
    step(1'b0, '0, 1'b1, 1'b0);
    idle(2);

    // R10: two-instance ring, write then read with enables held low
    for (int i = 0; i < 2 * DEPTH; i++) begin
      c_din = 18'(i + 'h100);
      c_wen_n = 1'b0;
      @(posedge clk);
      @(negedge clk);
      chk(w0 == (i != DEPTH - 1), "R10 write token 0", int'(w0), int'(i != DEPTH - 1));
      chk(w1 == (i != 2 * DEPTH - 1), "R10 write token 1", int'(w1),
          int'(i != 2 * DEPTH - 1));
    end
    c_wen_n = 1'b1;
    repeat (6) @(negedge clk);
    for (int j = 0; j < 2 * DEPTH; j++) begin
      c_ren_n = 1'b0;
      @(posedge clk);
      @(negedge clk);
      if (j < DEPTH)
        chk(c_dout0 === 18'(j + 'h100), "R10 ring data dev0", int'(c_dout0), j + 'h100);
      else
        chk(c_dout1 === 18'(j + 'h100), "R10 ring data dev1", int'(c_dout1), j + 'h100);
      chk(r0 == (j != DEPTH - 1), "R10 read token 0", int'(r0), int'(j != DEPTH - 1));
      chk(r1 == (j != 2 * DEPTH - 1), "R10 read token 1", int'(r1),
          int'(j != 2 * DEPTH - 1));
    end
    c_ren_n = 1'b1;
    repeat (2) @(negedge clk);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule